// File: doc/BRIEF.md
# Reset Boot Source Sequencer

This block runs once after every reset and decides where the processor begins execution: in the on-chip boot ROM or in a user image stored in flash. It takes a boot-strap setting (enable, polarity, port and pin selection), a 64-bit GPIO level bus arranged as eight ports of eight pins, and a single-request memory read channel into flash.

The decision runs in a fixed order. First comes an optional strap check on one chosen GPIO pin. Next, the vector word at address 0x4 is tested for blank flash. Last, the stack pointer and program counter are fetched from addresses 0x0 and 0x4. The result is held on the outputs for the core's reset logic, and a one-cycle done strobe marks when it is ready.

Top module: `boot_select_seq`

## Requirements
- R1: While the synchronous active-low reset is applied, `boot_rom`, `rom_remap`, `done` and `mem_req` are 0, and `sp_out` and `pc_out` are 0.
- R2: The GPIO bus is sampled once, on the first clock edge after reset is released. Later changes on `gpio_in` have no effect on the outcome.
- R3: The strap pin is bit `cfg_port*8 + cfg_pin` of `gpio_in`. Port codes 0..7 stand for ports A..H, and pin codes 0..7 stand for the pin within the port.
- R4: When `cfg_en` = 0, the chosen pin is not locked, and its sampled level equals `cfg_pol` (1 = high requests ROM, 0 = low requests ROM), the block sets `boot_rom` = 1 and `rom_remap` = 1, issues no memory read, and finishes.
- R5: Pins C0..C3, D7 and E7 (bits 16..19, 31 and 39) are locked. If one of them is chosen, the strap is ignored and the flash check runs.
- R6: When `cfg_en` = 1, or the strap does not request ROM, the first memory read goes to address 0x00000004.
- R7: If that word is 0xFFFFFFFF, `boot_rom` = 1 and `rom_remap` = 1, no further read is issued, and `sp_out`/`pc_out` stay 0.
- R8: Otherwise `pc_out` takes the word from 0x4. A second read then goes to 0x00000000, `sp_out` takes that word, and `boot_rom` = `rom_remap` = 0.
- R9: A read holds `mem_req` and `mem_addr` steady until `mem_valid` is seen, however long that takes. Only the `mem_rdata` present with `mem_valid` is used.
- R10: `done` is high for exactly one cycle per reset. From then until the next reset the outputs do not change and no read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | 0 enables the GPIO strap check |
| cfg_pol | input | 1 | Pin level that requests ROM boot |
| cfg_port | input | 3 | Strap port select (A..H) |
| cfg_pin | input | 3 | Strap pin select within the port |
| gpio_in | input | 64 | Pin levels, port-major (bit = port*8+pin) |
| mem_req | output | 1 | Flash read request |
| mem_addr | output | 32 | Flash read address |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| boot_rom | output | 1 | Start execution in boot ROM |
| rom_remap | output | 1 | Map ROM at address 0 |
| sp_out | output | 32 | Loaded stack pointer |
| pc_out | output | 32 | Loaded program counter |
| done | output | 1 | One-cycle decision-complete strobe |

## Verification
The assertions assume that the memory side raises `mem_valid` only while `mem_req` is high, at most once per request. They also assume that the configuration inputs do not change during a sequence. The bench's memory model answers only an outstanding request, after a chosen wait of 0 to 3 cycles. It drops `mem_valid` on the next cycle, and the configuration is set while reset is applied and then held.

// File: rtl/boot_sel_pkg.sv
// Package: shared state encoding for the boot source sequencer.
package boot_sel_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_CFG,
        ST_CHECK_PIN,
        ST_READ_VEC1,
        ST_READ_VEC0,
        ST_DONE
    } boot_state_e;
endpackage

// File: rtl/boot_strap_capture.sv
// Module: boot_strap_capture
// Holds the GPIO snapshot and the strap configuration for one sequence.
// Assumes: snap_gpio pulses in the first cycle after reset and snap_cfg
// pulses once afterwards; both captures are then frozen until reset.
module boot_strap_capture #(
    parameter int N_PORTS       = 8,
    parameter int PINS_PER_PORT = 8,
    localparam int PORT_W = $clog2(N_PORTS),
    localparam int PIN_W  = $clog2(PINS_PER_PORT),
    localparam int GPIO_W = N_PORTS * PINS_PER_PORT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snap_gpio,
    input  logic              snap_cfg,
    input  logic [GPIO_W-1:0] gpio_in,
    input  logic              cfg_en,
    input  logic              cfg_pol,
    input  logic [PORT_W-1:0] cfg_port,
    input  logic [PIN_W-1:0]  cfg_pin,
    output logic [GPIO_W-1:0] gpio_q,
    output logic              en_q,
    output logic              pol_q,
    output logic [PORT_W-1:0] port_q,
    output logic [PIN_W-1:0]  pin_q
);
    // Capture pin levels once after reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gpio_q <= '0;
        end else if (snap_gpio) begin
            gpio_q <= gpio_in;
        end
    end

    // Capture the strap configuration in the configuration-read step.
    // Reset value disables the strap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b1;
            pol_q  <= 1'b1;
            port_q <= '1;
            pin_q  <= '1;
        end else if (snap_cfg) begin
            en_q   <= cfg_en;
            pol_q  <= cfg_pol;
            port_q <= cfg_port;
            pin_q  <= cfg_pin;
        end
    end
endmodule

// File: rtl/boot_strap_eval.sv
// Module: boot_strap_eval
// Combinational strap decision: selects one pin of the snapshot, blocks
// pins that are locked at reset, and compares the level with the polarity.
// Assumes: inputs come from registers held steady during the sequence.
module boot_strap_eval #(
    parameter int N_PORTS       = 8,
    parameter int PINS_PER_PORT = 8,
    localparam int PORT_W = $clog2(N_PORTS),
    localparam int PIN_W  = $clog2(PINS_PER_PORT),
    localparam int GPIO_W = N_PORTS * PINS_PER_PORT,
    parameter logic [GPIO_W-1:0] LOCK_MASK = 64'h0000_0080_800F_0000
) (
    input  logic [GPIO_W-1:0] gpio_q,
    input  logic              en_q,
    input  logic              pol_q,
    input  logic [PORT_W-1:0] port_q,
    input  logic [PIN_W-1:0]  pin_q,
    output logic              strap_hit
);
    logic [N_PORTS-1:0] port_level;
    logic [N_PORTS-1:0] port_locked;

    // One pin selector per port; the port mux then picks among them.
    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
        logic [PINS_PER_PORT-1:0] lvl_slice;
        logic [PINS_PER_PORT-1:0] lock_slice;
        assign lvl_slice      = gpio_q[p*PINS_PER_PORT +: PINS_PER_PORT];
        assign lock_slice     = LOCK_MASK[p*PINS_PER_PORT +: PINS_PER_PORT];
        assign port_level[p]  = lvl_slice[pin_q];
        assign port_locked[p] = lock_slice[pin_q];
    end

    logic sel_level;
    logic sel_locked;

    // Select the chosen port's pin and lock status.
    always_comb begin
        sel_level  = port_level[port_q];
        sel_locked = port_locked[port_q];
        strap_hit  = !en_q && !sel_locked && (sel_level == pol_q);
    end
endmodule

// File: rtl/boot_seq_fsm.sv
// Module: boot_seq_fsm
// Sequencer: steps through configuration read, strap check, blank check
// and vector fetch, and registers the boot decision and loaded vectors.
// Assumes: mem_valid arrives only while mem_req is high; reads have no
// timeout.
module boot_seq_fsm
    import boot_sel_pkg::*;
#(
    parameter int            ADDR_W  = 32,
    parameter int            DATA_W  = 32,
    parameter logic [ADDR_W-1:0] SP_ADDR = 32'h0000_0000,
    parameter logic [ADDR_W-1:0] PC_ADDR = 32'h0000_0004
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_hit,
    input  logic              mem_valid,
    input  logic [DATA_W-1:0] mem_rdata,
    output boot_state_e       state,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              boot_rom,
    output logic              rom_remap,
    output logic [DATA_W-1:0] sp_out,
    output logic [DATA_W-1:0] pc_out,
    output logic              done
);
    localparam logic [DATA_W-1:0] BLANK_WORD = '1;

    boot_state_e state_nx;
    logic        vec1_blank;

    assign vec1_blank = (mem_rdata == BLANK_WORD);

    // Next-state selection in the fixed decision order.
    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE:      state_nx = ST_READ_CFG;
            ST_READ_CFG:  state_nx = ST_CHECK_PIN;
            ST_CHECK_PIN: state_nx = strap_hit ? ST_DONE : ST_READ_VEC1;
            ST_READ_VEC1: if (mem_valid) state_nx = vec1_blank ? ST_DONE : ST_READ_VEC0;
            ST_READ_VEC0: if (mem_valid) state_nx = ST_DONE;
            ST_DONE:      state_nx = ST_DONE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // Read channel driven straight from the state.
    always_comb begin
        mem_req  = (state == ST_READ_VEC1) || (state == ST_READ_VEC0);
        mem_addr = (state == ST_READ_VEC1) ? PC_ADDR : SP_ADDR;
    end

    // State register and one-cycle completion strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            done  <= 1'b0;
        end else begin
            state <= state_nx;
            done  <= (state_nx == ST_DONE) && (state != ST_DONE);
        end
    end

    // Boot decision and vector registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boot_rom  <= 1'b0;
            rom_remap <= 1'b0;
            sp_out    <= '0;
            pc_out    <= '0;
        end else begin
            if (state == ST_CHECK_PIN && strap_hit) begin
                boot_rom  <= 1'b1;
                rom_remap <= 1'b1;
            end
            if (state == ST_READ_VEC1 && mem_valid) begin
                if (vec1_blank) begin
                    boot_rom  <= 1'b1;
                    rom_remap <= 1'b1;
                end else begin
                    pc_out <= mem_rdata;
                end
            end
            if (state == ST_READ_VEC0 && mem_valid) begin
                sp_out <= mem_rdata;
            end
        end
    end
endmodule

// File: rtl/boot_select_seq.sv
// Module: boot_select_seq (top)
// After each reset, decides between boot ROM and flash application using a
// GPIO strap, a blank-flash test and a two-word vector fetch.
// Assumes: configuration inputs are steady from reset release until done.
module boot_select_seq
    import boot_sel_pkg::*;
#(
    parameter int N_PORTS       = 8,
    parameter int PINS_PER_PORT = 8,
    parameter int ADDR_W        = 32,
    parameter int DATA_W        = 32,
    localparam int PORT_W = $clog2(N_PORTS),
    localparam int PIN_W  = $clog2(PINS_PER_PORT),
    localparam int GPIO_W = N_PORTS * PINS_PER_PORT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              cfg_pol,
    input  logic [PORT_W-1:0] cfg_port,
    input  logic [PIN_W-1:0]  cfg_pin,
    input  logic [GPIO_W-1:0] gpio_in,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_valid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              boot_rom,
    output logic              rom_remap,
    output logic [DATA_W-1:0] sp_out,
    output logic [DATA_W-1:0] pc_out,
    output logic              done
);
    boot_state_e       state;
    logic [GPIO_W-1:0] gpio_q;
    logic              en_q;
    logic              pol_q;
    logic [PORT_W-1:0] port_q;
    logic [PIN_W-1:0]  pin_q;
    logic              strap_hit;

    boot_strap_capture #(
        .N_PORTS(N_PORTS), .PINS_PER_PORT(PINS_PER_PORT)
    ) u_capture (
        .clk(clk), .rst_n(rst_n),
        .snap_gpio(state == ST_IDLE),
        .snap_cfg(state == ST_READ_CFG),
        .gpio_in(gpio_in),
        .cfg_en(cfg_en), .cfg_pol(cfg_pol),
        .cfg_port(cfg_port), .cfg_pin(cfg_pin),
        .gpio_q(gpio_q), .en_q(en_q), .pol_q(pol_q),
        .port_q(port_q), .pin_q(pin_q)
    );

    boot_strap_eval #(
        .N_PORTS(N_PORTS), .PINS_PER_PORT(PINS_PER_PORT)
    ) u_eval (
        .gpio_q(gpio_q), .en_q(en_q), .pol_q(pol_q),
        .port_q(port_q), .pin_q(pin_q),
        .strap_hit(strap_hit)
    );

    boot_seq_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .strap_hit(strap_hit),
        .mem_valid(mem_valid), .mem_rdata(mem_rdata),
        .state(state),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .boot_rom(boot_rom), .rom_remap(rom_remap),
        .sp_out(sp_out), .pc_out(pc_out),
        .done(done)
    );
endmodule

// File: rtl/boot_select_seq_chk.sv
// Module: boot_select_seq_chk
// Port-level protocol checks for the sequencer, bound to the top module.
// Assumes: mem_valid is only returned for an outstanding request.
module boot_select_seq_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_valid,
    input logic              boot_rom,
    input logic              rom_remap,
    input logic [DATA_W-1:0] sp_out,
    input logic [DATA_W-1:0] pc_out,
    input logic              done
);
    logic finished;

    // Remember that the strobe has been seen since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) finished <= 1'b0;
        else if (done) finished <= 1'b1;
    end

    // R1: nothing requested or flagged in the first cycle out of reset.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !mem_req && !done && !boot_rom && !rom_remap);

    // R9: a pending read keeps request and address until valid.
    assert_req_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_valid |=> mem_req && $stable(mem_addr));

    // R6/R8: only the two vector addresses are ever read.
    assert_legal_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr == 32'h4 || mem_addr == 32'h0));

    // R10: strobe lasts exactly one cycle.
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: outputs frozen and bus idle once finished.
    assert_outputs_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        finished |=> $stable(sp_out) && $stable(pc_out) && $stable(boot_rom)
                     && $stable(rom_remap) && !mem_req && !done);

    // R7/R8: ROM boot and remap agree whenever the decision is reported.
    assert_rom_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> boot_rom == rom_remap);
endmodule

bind boot_select_seq boot_select_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
    .boot_rom(boot_rom), .rom_remap(rom_remap),
    .sp_out(sp_out), .pc_out(pc_out), .done(done)
);

// File: tb/tb_boot_select_seq.sv
module tb_boot_select_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en = 1'b1, cfg_pol = 1'b1;
    logic [2:0]  cfg_port = 3'd7, cfg_pin = 3'd7;
    logic [63:0] gpio_in = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_valid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        boot_rom, rom_remap, done;
    logic [31:0] sp_out, pc_out;

    int n_chk = 0, n_fail = 0, cycles = 0;
    int lat = 0, wait_cnt = 0, rd_n = 0;
    logic [31:0] vec0 = '0, vec1 = '0;
    logic [31:0] rd_addr [0:3];

    always #10 clk = ~clk;

    boot_select_seq dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_en(cfg_en), .cfg_pol(cfg_pol), .cfg_port(cfg_port), .cfg_pin(cfg_pin),
        .gpio_in(gpio_in),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_valid(mem_valid), .mem_rdata(mem_rdata),
        .boot_rom(boot_rom), .rom_remap(rom_remap),
        .sp_out(sp_out), .pc_out(pc_out), .done(done)
    );

    // Flash model: answers an outstanding request after lat idle cycles.
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_valid = 1'b0; wait_cnt = 0; rd_n = 0;
        end else if (mem_valid) begin
            mem_valid = 1'b0; wait_cnt = 0;
        end else if (mem_req) begin
            if (wait_cnt >= lat) begin
                mem_valid = 1'b1;
                mem_rdata = (mem_addr == 32'h4) ? vec1 : vec0;
                if (rd_n < 4) rd_addr[rd_n] = mem_addr;
                rd_n = rd_n + 1;
            end else begin
                wait_cnt = wait_cnt + 1;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run_case(input bit en, input bit pol, input int port, input int pin,
                            input bit level, input logic [31:0] v1, input logic [31:0] v0,
                            input int latency);
        int idx = port*8 + pin;
        bit locked = (port == 2 && pin < 4) || (pin == 7 && (port == 3 || port == 4));
        bit strap = !en && !locked && (level == pol);
        bit blank = (v1 == 32'hFFFF_FFFF);
        bit exp_rom = strap || blank;
        int exp_reads = strap ? 0 : (blank ? 1 : 2);
        int dones = 0;
        logic [31:0] sp_at, pc_at;
        logic rom_at;
        @(negedge clk);
        rst_n = 1'b0;
        cfg_en = en; cfg_pol = pol; cfg_port = 3'(port); cfg_pin = 3'(pin);
        gpio_in = level ? (64'd1 << idx) : ~(64'd1 << idx);
        vec1 = v1; vec0 = v0; lat = latency;
        @(negedge clk); @(negedge clk);
        // R1: reset state at the ports
        chk("R1", {26'd0, mem_req, done, boot_rom, rom_remap, 1'b0, |{sp_out, pc_out}}, 32'd0);
        rst_n = 1'b1;
        sp_at = '0; pc_at = '0; rom_at = 1'b0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (i == 0) gpio_in = ~gpio_in;   // R2: late change must be ignored
            if (done) begin
                dones++;
                sp_at = sp_out; pc_at = pc_out; rom_at = boot_rom;
            end
        end
        chk("R2/R3/R4/R5/R7 boot_rom", {31'd0, boot_rom}, {31'd0, exp_rom});
        chk("R4/R7/R8 rom_remap", {31'd0, rom_remap}, {31'd0, exp_rom});
        chk("R6/R7/R8 read count", rd_n, exp_reads);
        if (exp_reads >= 1) chk("R6 first read addr", rd_addr[0], 32'h4);
        if (exp_reads == 2) chk("R8/R9 second read addr", rd_addr[1], 32'h0);
        chk("R8 pc_out", pc_out, (exp_reads == 2) ? v1 : 32'h0);
        chk("R8 sp_out", sp_out, (exp_reads == 2) ? v0 : 32'h0);
        chk("R10 done count", dones, 1);
        chk("R10 stable", {30'd0, (sp_at != sp_out || pc_at != pc_out), rom_at != boot_rom}, 32'd0);
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int en = 0; en < 2; en++)
            for (int port = 0; port < 8; port++)
                for (int pin = 0; pin < 8; pin++)
                    for (int pol = 0; pol < 2; pol++)
                        for (int lv = 0; lv < 2; lv++) begin
                            int sel = (port + pin + pol + lv) % 3;
                            logic [31:0] v1 = (sel == 0) ? 32'hFFFF_FFFF :
                                              (sel == 1) ? 32'hFFFF_FFFE :
                                              32'h0000_1000 + 32'(port*64 + pin*8 + pol*2 + lv);
                            logic [31:0] v0 = 32'h2000_8000 + 32'(port*256 + pin*16 + en);
                            run_case(en[0], pol[0], port, pin, lv[0], v1, v0, (port + pin + lv) % 4);
                        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule